// File: doc/BRIEF.md
# I2C register transaction sequencer

This block sits between a piece of control logic and a byte-level I2C master. It turns a single request into the sequence of byte-level commands that reads or writes registers in a port-expander style device. The caller gives a device address, a register address, a direction and a byte count. On a write, the block pulls data bytes from the caller one at a time. On a read, it hands each received byte back with a valid pulse. When the transaction ends, the block raises a one-cycle done pulse and a latched error flag. The caller should accept captured read data only while that flag is clear.

Each command goes to the byte master through a strobe/accept handshake. The command code and the byte are set up one cycle before the strobe rises, and they stay held for one cycle after the master accepts. If a byte the block sends gets a NACK, the block sends nothing more: no further data bytes and no repeated start. It goes straight to a stop, so other devices on the bus never see stray bytes. A master that stops answering is caught by a timeout. The block accepts a new request as soon as the previous one is done, including after a failure.

Top module: `i2c_xact_seq`

## Requirements
- R1: A write request issues, in this order: start (m_cmd 1), write byte (m_cmd 2) of {dev_addr,0}, write byte of reg_addr, one write byte per data byte in caller order, and then stop (m_cmd 5). The idle code on m_cmd is 0.
- R2: A read request issues, in this order: start, write {dev_addr,0}, write reg_addr, repeated start (m_cmd 4), write {dev_addr,1}, byte_count read-byte commands (m_cmd 3), and then stop.
- R3: When the master reports m_nack on the accept of any write-byte command, the next command is stop, and after that stop the bus sees no more commands for that request.
- R4: done is a single-cycle pulse. err is updated only in the cycle done is high, and err keeps its value until the next done. After reset, err, done, busy and m_strobe are 0.
- R5: m_cmd and m_tx do not change in the cycle m_strobe rises. m_strobe falls in the cycle after the accept, and m_cmd and m_tx stay unchanged for that cycle.
- R6: m_rd_nack is 1 on the final read-byte command of a read and 0 on every other command, so every read byte is acknowledged except the last.
- R7: A write request with byte_count 0 issues start, the device address byte, the register address byte and then stop, and reports success.
- R8: A read request with byte_count 0 produces done with err=1 in the next cycle and never raises m_strobe.
- R9: If m_accept stays low for more than timeout_limit+1 strobe cycles, the block drops the strobe and sets err. It then issues a stop, unless the stop itself was the command that hung, in which case it ends at once.
- R10: A req that arrives while busy is high has no effect on the bus sequence and produces no extra done.
- R11: Each read byte is returned on rd_data with a one-cycle rd_valid pulse, in bus order. wr_ready pulses once each time a data byte is taken from wr_data, after which the caller presents the next byte.
- R12: A request issued right after a failed transaction runs its full, correct sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction (sampled while idle) |
| rw | input | 1 | 1 = read, 0 = write |
| dev_addr | input | 7 | Target device address |
| reg_addr | input | 8 | Target register address |
| byte_count | input | CNT_W | Number of data bytes |
| wr_data | input | 8 | Current write data byte from the caller |
| wr_ready | output | 1 | Pulse: wr_data was taken, present the next byte |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| done | output | 1 | Pulse: transaction finished |
| err | output | 1 | Latched outcome, 1 = failed |
| busy | output | 1 | A transaction is in progress |
| timeout_limit | input | TO_W | Strobe cycles allowed before timeout, minus one |
| m_cmd | output | 3 | Command code to the byte master |
| m_tx | output | 8 | Byte to send with a write command |
| m_rd_nack | output | 1 | NACK the byte of this read command |
| m_strobe | output | 1 | Command request to the byte master |
| m_accept | input | 1 | Master finished the command |
| m_nack | input | 1 | Slave NACKed the byte, valid with m_accept |
| m_rx | input | 8 | Byte read, valid with m_accept |

## Verification
Directed cases cover the fixed points of the command sequence: writes with zero, one and several data bytes, reads with one and several bytes, and a read with count zero. Between them they separate the repeated start, the read bit in the address and the placement of the final read NACK. NACKs are injected on the device address, the register address and on a middle data byte. These show whether the abort skips the repeated start and the remaining data, and a clean request that follows each one shows the recovery. Master hangs on a middle command and on the stop itself exercise the two exits from the timeout. A second req while busy checks that it is ignored. Random requests with random counts, addresses, data, NACK positions and master latencies are compared command by command against a sequence the bench builds from the requirements.

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq #(
  parameter int CNT_W = 4,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             rw,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       reg_addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             err,
  output logic             busy,
  input  logic [TO_W-1:0]  timeout_limit,
  output logic [2:0]       m_cmd,
  output logic [7:0]       m_tx,
  output logic             m_rd_nack,
  output logic             m_strobe,
  input  logic             m_accept,
  input  logic             m_nack,
  input  logic [7:0]       m_rx
);
  localparam logic [2:0] C_IDLE = 3'd0, C_START = 3'd1, C_WRITE = 3'd2,
                         C_READ = 3'd3, C_RSTART = 3'd4, C_STOP = 3'd5;

  typedef enum logic [1:0] {P_IDLE, P_PREP, P_ISSUE, P_HOLD} phase_t;
  typedef enum logic [2:0] {S_START, S_DEVW, S_REG, S_WDAT,
                            S_RST, S_DEVR, S_RDAT, S_STOP} step_t;

  phase_t           phase;
  step_t            step, nxt;
  logic             rw_q, fail;
  logic [6:0]       dev_q;
  logic [7:0]       reg_q, ntx;
  logic [2:0]       ncmd;
  logic [CNT_W-1:0] remain;
  logic [TO_W-1:0]  tcnt;

  assign busy = (phase != P_IDLE);

  always_comb begin
    nxt = S_STOP;
    if (!fail) begin
      case (step)
        S_START: nxt = S_DEVW;
        S_DEVW:  nxt = S_REG;
        S_REG:   nxt = rw_q ? S_RST : ((remain == '0) ? S_STOP : S_WDAT);
        S_WDAT:  nxt = (remain == '0) ? S_STOP : S_WDAT;
        S_RST:   nxt = S_DEVR;
        S_DEVR:  nxt = S_RDAT;
        S_RDAT:  nxt = (remain == '0) ? S_STOP : S_RDAT;
        default: nxt = S_STOP;
      endcase
    end
  end

  always_comb begin
    ncmd = C_STOP;
    ntx  = 8'h00;
    case (nxt)
      S_START: ncmd = C_START;
      S_DEVW:  begin ncmd = C_WRITE; ntx = {dev_q, 1'b0}; end
      S_REG:   begin ncmd = C_WRITE; ntx = reg_q; end
      S_WDAT:  begin ncmd = C_WRITE; ntx = wr_data; end
      S_RST:   ncmd = C_RSTART;
      S_DEVR:  begin ncmd = C_WRITE; ntx = {dev_q, 1'b1}; end
      S_RDAT:  ncmd = C_READ;
      default: ncmd = C_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;  step <= S_START;
      rw_q <= 1'b0;     fail <= 1'b0;
      dev_q <= '0;      reg_q <= '0;
      remain <= '0;     tcnt <= '0;
      m_cmd <= C_IDLE;  m_tx <= '0;
      m_rd_nack <= 1'b0; m_strobe <= 1'b0;
      done <= 1'b0;     err <= 1'b0;
      wr_ready <= 1'b0; rd_valid <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      wr_ready <= 1'b0;
      rd_valid <= 1'b0;
      case (phase)
        P_IDLE: if (req) begin
          if (rw && byte_count == '0) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            rw_q <= rw; dev_q <= dev_addr; reg_q <= reg_addr;
            remain <= byte_count; fail <= 1'b0;
            step <= S_START; m_cmd <= C_START; m_tx <= '0; m_rd_nack <= 1'b0;
            phase <= P_PREP;
          end
        end
        P_PREP: begin
          m_strobe <= 1'b1;
          tcnt <= '0;
          phase <= P_ISSUE;
        end
        P_ISSUE: if (m_accept) begin
          m_strobe <= 1'b0;
          phase <= P_HOLD;
          if (m_nack && m_cmd == C_WRITE) fail <= 1'b1;
          if (step == S_RDAT) begin rd_data <= m_rx; rd_valid <= 1'b1; end
          if (step == S_WDAT || step == S_RDAT) remain <= remain - 1'b1;
        end else if (tcnt == timeout_limit) begin
          m_strobe <= 1'b0;
          fail <= 1'b1;
          if (step == S_STOP) begin
            phase <= P_IDLE; done <= 1'b1; err <= 1'b1; m_cmd <= C_IDLE;
          end else begin
            step <= S_STOP; m_cmd <= C_STOP; m_tx <= '0; m_rd_nack <= 1'b0;
            phase <= P_PREP;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        default: if (step == S_STOP) begin
          phase <= P_IDLE; done <= 1'b1; err <= fail; m_cmd <= C_IDLE;
        end else begin
          step <= nxt; m_cmd <= ncmd; m_tx <= ntx;
          m_rd_nack <= (nxt == S_RDAT) && (remain == 1);
          wr_ready <= (nxt == S_WDAT);
          phase <= P_PREP;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_xact_seq_chk.sv
module i2c_xact_seq_chk #(
  parameter int TO_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [2:0]      m_cmd,
  input logic [7:0]      m_tx,
  input logic            m_strobe,
  input logic            m_accept,
  input logic            m_nack,
  input logic [TO_W-1:0] timeout_limit
);
  logic          pend_abort;
  logic [TO_W:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_abort <= 1'b0;
      wait_cnt <= '0;
    end else begin
      if (done) pend_abort <= 1'b0;
      else if (m_strobe && m_accept && m_nack && m_cmd == 3'd2) pend_abort <= 1'b1;
      if (!m_strobe || m_accept) wait_cnt <= '0;
      else wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assert_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_strobe) |-> $stable(m_cmd) && $stable(m_tx));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_strobe && m_accept |=> !m_strobe && $stable(m_cmd) && $stable(m_tx));
  assert_abort_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_strobe && pend_abort |-> m_cmd == 3'd5);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_strobe);
  assert_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_strobe |-> wait_cnt <= {1'b0, timeout_limit});
endmodule

bind i2c_xact_seq i2c_xact_seq_chk #(.TO_W(TO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .m_cmd(m_cmd), .m_tx(m_tx), .m_strobe(m_strobe), .m_accept(m_accept),
  .m_nack(m_nack), .timeout_limit(timeout_limit)
);

// File: tb/tb_i2c_xact_seq.sv
module tb_i2c_xact_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rw = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [7:0] reg_addr = '0, wr_data = '0;
  logic [3:0] byte_count = '0;
  logic [15:0] timeout_limit = 16'd30;
  logic m_accept, m_nack;
  logic [7:0] m_rx;
  logic wr_ready, rd_valid, done, err, busy, m_rd_nack, m_strobe;
  logic [7:0] rd_data, m_tx;
  logic [2:0] m_cmd;

  i2c_xact_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  logic [7:0] wbytes [0:16];
  logic [7:0] rbytes [0:16];
  logic [7:0] rd_got [0:16];
  logic [2:0] exp_cmd [0:63];
  logic [7:0] exp_tx  [0:63];
  logic       exp_rn  [0:63];
  logic [2:0] log_cmd [0:63];
  logic [7:0] log_tx  [0:63];
  logic       log_rn  [0:63];
  int n_exp, n_log, n_rd, widx, wcount, ridx, cmdidx, nack_at = -1, hang_at = -1, dly;
  bit exp_err, hung, got_err;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [7:0] t, input logic rn);
    exp_cmd[n_exp] = c; exp_tx[n_exp] = t; exp_rn[n_exp] = rn; n_exp++;
  endtask

  task automatic build_exp(input bit r, input int cnt, input logic [6:0] d,
                           input logic [7:0] ra, input int nk, input int hg);
    int w;
    n_exp = 0; exp_err = 0;
    if (r && cnt == 0) begin exp_err = 1; return; end
    push(3'd1, 8'h00, 1'b0);
    push(3'd2, {d, 1'b0}, 1'b0);
    push(3'd2, ra, 1'b0);
    if (!r) begin
      for (int i = 0; i < cnt; i++) push(3'd2, wbytes[i], 1'b0);
    end else begin
      push(3'd4, 8'h00, 1'b0);
      push(3'd2, {d, 1'b1}, 1'b0);
      for (int i = 0; i < cnt; i++) push(3'd3, 8'h00, i == cnt - 1);
    end
    push(3'd5, 8'h00, 1'b0);
    w = 0;
    for (int k = 0; k < n_exp; k++) begin
      if (exp_cmd[k] == 3'd2) begin
        if (w == nk) begin
          n_exp = k + 1; push(3'd5, 8'h00, 1'b0); exp_err = 1; break;
        end
        w++;
      end
    end
    if (hg >= 0 && hg < n_exp) begin
      exp_err = 1;
      if (hg == n_exp - 1) n_exp = hg;
      else begin n_exp = hg; push(3'd5, 8'h00, 1'b0); end
    end
  endtask

  initial begin
    m_accept = 0; m_nack = 0; m_rx = 0; dly = 0; hung = 0;
    forever begin
      @(negedge clk);
      m_accept = 0; m_nack = 0;
      if (!m_strobe && hung) begin hung = 0; cmdidx++; end
      if (m_strobe) begin
        if (cmdidx == hang_at) hung = 1;
        else if (dly > 0) dly--;
        else begin
          m_accept = 1;
          if (m_cmd == 3'd2) begin m_nack = (wcount == nack_at); wcount++; end
          if (m_cmd == 3'd3) begin m_rx = rbytes[ridx]; ridx++; end
          log_cmd[n_log] = m_cmd; log_tx[n_log] = m_tx; log_rn[n_log] = m_rd_nack;
          n_log++; cmdidx++;
          dly = $urandom % 3;
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rd_valid) begin rd_got[n_rd] = rd_data; n_rd++; end
    if (wr_ready) begin widx++; wr_data = wbytes[widx]; end
  end

  task automatic run(input bit r, input int cnt, input int nk, input int hg,
                     input bit poke, input string tag);
    logic [6:0] d; logic [7:0] ra; bit got; int bad, first, n_r, n_w;
    d = 7'($urandom); ra = 8'($urandom);
    for (int i = 0; i < 17; i++) begin wbytes[i] = 8'($urandom); rbytes[i] = 8'($urandom); end
    build_exp(r, cnt, d, ra, nk, hg);
    n_log = 0; n_rd = 0; widx = 0; wcount = 0; ridx = 0; cmdidx = 0;
    nack_at = nk; hang_at = hg; hung = 0;
    @(negedge clk);
    rw = r; dev_addr = d; reg_addr = ra; byte_count = 4'(cnt); wr_data = wbytes[0]; req = 1;
    got = 0; got_err = 0;
    for (int cyc = 0; cyc < 3000 && !got; cyc++) begin
      @(negedge clk);
      req = poke && cyc == 3;
      if (poke && cyc == 3) begin rw = ~r; byte_count = 4'd5; end
      if (done) begin got = 1; got_err = err; end
    end
    chk(got, {tag, " done seen"}, int'(got), 1);
    chk(got_err == exp_err, {tag, " err at done"}, int'(got_err), int'(exp_err));
    repeat (poke ? 30 : 4) @(negedge clk);
    chk(!busy && err == got_err, {tag, " R4 idle with err held"}, int'(err), int'(got_err));
    chk(n_log == n_exp, {tag, " command count"}, n_log, n_exp);
    bad = 0; first = -1;
    for (int k = 0; k < n_exp && k < n_log; k++)
      if (log_cmd[k] != exp_cmd[k] || log_tx[k] != exp_tx[k] || log_rn[k] != exp_rn[k]) begin
        bad++; if (first < 0) first = k;
      end
    if (first >= 0)
      $display("FAIL %s command %0d actual cmd=%0d tx=%0h rn=%0d expected cmd=%0d tx=%0h rn=%0d",
               tag, first, log_cmd[first], log_tx[first], log_rn[first],
               exp_cmd[first], exp_tx[first], exp_rn[first]);
    total++; if (bad != 0) fails++;
    n_r = 0; n_w = 0;
    for (int k = 0; k < n_exp; k++) begin
      if (exp_cmd[k] == 3'd3) n_r++;
      if (exp_cmd[k] == 3'd2) n_w++;
    end
    bad = 0;
    for (int i = 0; i < n_r && i < n_rd; i++) if (rd_got[i] != rbytes[i]) bad++;
    chk(n_rd == n_r && bad == 0, {tag, " R11 read data"}, n_rd, n_r);
    if (hg < 0 && !r)
      chk(widx == ((n_w > 2) ? n_w - 2 : 0), {tag, " R11 write pulls"}, widx, (n_w > 2) ? n_w - 2 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !m_strobe && m_cmd == 3'd0, "R4 reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 2, -1, -1, 0, "R1 write two bytes");
    run(0, 1, -1, -1, 0, "R1 write one byte");
    run(1, 3, -1, -1, 0, "R2 R6 read three bytes");
    run(1, 1, -1, -1, 0, "R6 read one byte last nack");
    run(0, 0, -1, -1, 0, "R7 write count zero");
    run(1, 0, -1, -1, 0, "R8 read count zero");
    run(0, 3, 0, -1, 0, "R3 nack on device address");
    run(1, 2, 1, -1, 0, "R3 read nack on register skips restart");
    run(0, 4, 3, -1, 0, "R3 nack on middle data byte");
    run(0, 2, -1, -1, 0, "R12 write after failure");
    run(1, 2, 2, -1, 0, "R3 nack on read address");
    run(1, 4, -1, -1, 0, "R12 read after failure");
    run(0, 2, -1, 2, 0, "R9 timeout mid transaction");
    run(0, 0, -1, 3, 0, "R9 timeout on stop");
    run(1, 2, -1, -1, 0, "R12 read after timeout");
    run(0, 3, -1, -1, 1, "R10 req while busy");
    for (int t = 0; t < 40; t++) begin
      bit r; int cnt, nk, nw;
      r = 1'($urandom);
      cnt = $urandom % 8;
      if (r && cnt == 0) cnt = 1;
      nw = r ? 3 : 2 + cnt;
      nk = (($urandom % 10) < 3) ? int'($urandom % nw) : -1;
      run(r, cnt, nk, -1, 0, "R1 R2 R3 R12 random");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule